// File: doc/BRIEF.md
# I2C Target with Byte-Level Clock Stretching

This block is an I2C target with a fixed 7-bit address, set by a parameter. It samples the open-drain SCL and SDA lines through synchronizers and detects START, repeated START and STOP conditions on them. It takes the first byte after any START as an address, acknowledges that byte when the address matches, and then receives or sends data bytes. The direction bit in that byte selects which.

The local side is a pair of byte channels with a ready/valid handshake. In the write direction, each received byte is acknowledged and then offered on `rx_data` with `rx_valid`. In the read direction, the block raises `tx_ready` and waits for a byte on `tx_data` with `tx_valid`. In both directions the target pulls SCL low once the acknowledge clock has finished. It lets SCL go only when the local handshake completes, so slow logic behind it sets the pace of the bus. Both lines are driven through active-high pull-down enables. The board or bench provides the wired-AND.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid` and `tx_ready` are all low.
- R2: A first byte after START whose bits [7:1] (sent MSB first) equal `OWN_ADDR` is acknowledged. The target pulls SDA low during the ninth clock. Bit 0 of that byte selects the direction: 1 means read and 0 means write.
- R3: A first byte with any other address gets no acknowledge. Until the next START or STOP, no later byte is acknowledged, SCL is never held and `rx_valid` stays low.
- R4: In write direction, each data byte is shifted in MSB first and acknowledged. After the ninth clock it appears on `rx_data` with `rx_valid` high, and SCL is held low until `rx_ready` is seen high.
- R5: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` does not change.
- R6: In read direction, after the address acknowledge, SCL is held low with `tx_ready` high until `tx_valid` is high. The byte taken is then sent MSB first.
- R7: The target changes its SDA drive only while SCL is low.
- R8: In read direction, a low SDA from the master on the ninth clock (ACK) makes the target stretch SCL and request the next byte. A high SDA (NACK) ends transmission: SDA is released, SCL is not held, and no further byte is requested.
- R9: A repeated START without a STOP returns the target to address matching, so a new address and direction take effect.
- R10: A STOP returns the target to idle with SCL and SDA released.
- R11: A START or STOP in the middle of a byte clears the bit count, so the next byte is framed from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | Received byte is available |
| rx_ready | input | 1 | Local side takes the received byte |
| tx_data | input | 8 | Byte to send to the master |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Target waits for a byte to send |

## Verification
The bench uses a stretch-aware master model to exercise the target. It runs writes with a slow consumer and reads with a slow producer, so SCL is held for many cycles and the bench can measure that hold. Data values with both polarities in the MSB and mixed bit patterns expose shift-order errors. A neighbouring address tells a full address compare apart from a partial one. An ACK-ACK-NACK read sequence tells continued transmission apart from its end. A repeated START switching write to read, a START cut into an address byte and a STOP cut into a data byte each show whether framing restarts cleanly.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BITS,
        S_WR_ACK,
        S_WR_HOLD,
        S_RD_HOLD,
        S_RD_LOAD,
        S_RD_BITS,
        S_RD_ACK,
        S_PARK
    } tgt_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_BITS-1:0] first_byte,
                                      input logic [6:0] own);
        return first_byte[BYTE_BITS-1:1] == own;
    endfunction

    function automatic logic holds_clock(input tgt_state_e st);
        return (st == S_WR_HOLD) || (st == S_RD_HOLD) || (st == S_RD_LOAD);
    endfunction

endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    logic scl_now, sda_now, scl_was, sda_was;
    assign scl_now = synced[1];
    assign sda_now = synced[0];
    assign scl_was = prev[1];
    assign sda_was = prev[0];

    always_comb begin
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_was;
        ev.scl_fall = ~scl_now & scl_was;
        ev.start    = scl_now & scl_was & sda_was & ~sda_now;
        ev.stop     = scl_now & scl_was & ~sda_was & sda_now;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h2A
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_ev_t              ev,
    input  logic                 rx_ready,
    input  logic [BYTE_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output tgt_state_e           state,
    output logic [BYTE_BITS-1:0] shreg,
    output logic                 sda_drv
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

    logic [CNT_W-1:0] cnt;
    logic             rd_dir;
    logic             mst_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            sda_drv <= 1'b0;
            rd_dir  <= 1'b0;
            mst_ack <= 1'b0;
        end else if (ev.start) begin
            state   <= S_ADDR;
            cnt     <= '0;
            sda_drv <= 1'b0;
        end else if (ev.stop) begin
            state   <= S_IDLE;
            cnt     <= '0;
            sda_drv <= 1'b0;
        end else begin
            case (state)
                S_ADDR, S_WR_BITS: begin
                    if (ev.scl_rise && cnt != FULL) begin
                        shreg <= {shreg[BYTE_BITS-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (state == S_WR_BITS) begin
                            sda_drv <= 1'b1;
                            state   <= S_WR_ACK;
                        end else if (addr_hit(shreg, OWN_ADDR)) begin
                            sda_drv <= 1'b1;
                            rd_dir  <= shreg[0];
                            state   <= S_ADDR_ACK;
                        end else begin
                            state <= S_PARK;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        sda_drv <= 1'b0;
                        state   <= rd_dir ? S_RD_HOLD : S_WR_BITS;
                    end
                end
                S_WR_ACK: begin
                    if (ev.scl_fall) begin
                        sda_drv <= 1'b0;
                        state   <= S_WR_HOLD;
                    end
                end
                S_WR_HOLD: begin
                    if (rx_ready) state <= S_WR_BITS;
                end
                S_RD_HOLD: begin
                    if (tx_valid) begin
                        shreg   <= tx_data;
                        sda_drv <= ~tx_data[BYTE_BITS-1];
                        cnt     <= '0;
                        state   <= S_RD_LOAD;
                    end
                end
                S_RD_LOAD: state <= S_RD_BITS;
                S_RD_BITS: begin
                    if (ev.scl_fall) begin
                        if (cnt == LAST) begin
                            sda_drv <= 1'b0;
                            cnt     <= '0;
                            state   <= S_RD_ACK;
                        end else begin
                            shreg   <= {shreg[BYTE_BITS-2:0], 1'b0};
                            sda_drv <= ~shreg[BYTE_BITS-2];
                            cnt     <= cnt + 1'b1;
                        end
                    end
                end
                S_RD_ACK: begin
                    if (ev.scl_rise) mst_ack <= ~ev.sda;
                    else if (ev.scl_fall) state <= mst_ack ? S_RD_HOLD : S_PARK;
                end
                default: ;
            endcase
        end
    end

    // R10: a STOP anywhere leaves the engine idle with SDA released
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == S_IDLE && !sda_drv));

    // R11: a START anywhere restarts address framing from bit zero
    a_r11_start_frames: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == S_ADDR && cnt == '0));

    // R7: during read data, SDA drive moves only on a detected SCL fall
    a_r7_sda_steady: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD_BITS && !ev.scl_fall && !ev.start && !ev.stop) |=> $stable(sda_drv));

    // R3: an unaddressed target never pulls SDA
    a_r3_park_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_PARK) |-> !sda_drv);

endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready
);
    bus_ev_t    ev;
    tgt_state_e st;
    logic [BYTE_BITS-1:0] shreg;
    logic       sda_drv;

    i2c_tgt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_engine #(.OWN_ADDR(OWN_ADDR)) i_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rx_ready (rx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .state    (st),
        .shreg    (shreg),
        .sda_drv  (sda_drv)
    );

    assign scl_oe   = holds_clock(st);
    assign sda_oe   = sda_drv;
    assign rx_data  = shreg;
    assign rx_valid = (st == S_WR_HOLD);
    assign tx_ready = (st == S_RD_HOLD);

    // R5: an offered byte stays put until the local side takes it
    a_r5_rx_stable: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R6: the request for a byte to send persists until one arrives
    a_r6_tx_wait: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |=> (tx_ready && scl_oe));

endmodule

// File: tb/test_i2c_stretch_target.sv
module test_i2c_stretch_target;
    localparam int         Q   = 10;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic [7:0] rx_data, tx_data;
    logic rx_valid, rx_ready, tx_valid, tx_ready;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2c_stretch_target #(.OWN_ADDR(OWN)) i_i2c_stretch_target (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int n_chk = 0, n_bad = 0;
    int rx_delay = 20, tx_delay = 20;
    int hold_bad = 0, sda_bad = 0;
    int rx_cnt = 0, tx_idx = 0;
    logic [7:0] rx_log [0:31];
    logic [7:0] tx_mem [0:7];
    logic scl_seen = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // local consumer: waits rx_delay cycles, checking the hold, then takes the byte
    initial begin
        rx_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_valid === 1'b1) begin
                logic [7:0] snap;
                snap = rx_data;
                repeat (rx_delay) begin
                    @(negedge clk);
                    if (scl_line !== 1'b0 || rx_valid !== 1'b1 || rx_data !== snap) hold_bad++;
                end
                rx_log[rx_cnt % 32] = snap;
                rx_cnt++;
                rx_ready = 1'b1;
                @(negedge clk);
                rx_ready = 1'b0;
            end
        end
    end

    // local producer: waits tx_delay cycles, checking the hold, then offers a byte
    initial begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (tx_ready === 1'b1) begin
                repeat (tx_delay) begin
                    @(negedge clk);
                    if (scl_line !== 1'b0 || tx_ready !== 1'b1) hold_bad++;
                end
                tx_data  = tx_mem[tx_idx % 8];
                tx_valid = 1'b1;
                @(negedge clk);
                tx_valid = 1'b0;
                tx_idx++;
            end
        end
    end

    // SDA drive must not move while SCL is high (R7); SCL hold observation (R3)
    logic sda_prev = 1'b0, scl_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst && sda_oe !== sda_prev && scl_line && scl_prev) sda_bad++;
        if (scl_oe === 1'b1) scl_seen = 1'b1;
        sda_prev = sda_oe;
        scl_prev = scl_line;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_high();
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic m_bit_out(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wait_high(); wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_bit_in(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_high(); wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
        m_bit_in(b);
        ack = ~b;
    endtask

    task automatic m_read_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_in(b);
            d[i] = b;
        end
        m_bit_out(~ack);
    endtask

    task automatic t_reset();
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 tx_ready", tx_ready, 0);
    endtask

    task automatic t_write();
        logic ack; int base;
        rx_delay = 40; hold_bad = 0; base = rx_cnt;
        m_start();
        m_write_byte({OWN, 1'b0}, ack); chk("R2 address ack (write)", ack, 1);
        m_write_byte(8'hA5, ack);       chk("R4 data ack 1", ack, 1);
        m_write_byte(8'h3C, ack);       chk("R4 data ack 2", ack, 1);
        m_stop(); wq();
        chk("R4 byte count", rx_cnt - base, 2);
        chk("R4 first byte", rx_log[base % 32], 8'hA5);
        chk("R4 second byte", rx_log[(base + 1) % 32], 8'h3C);
        chk("R5 held with stable data", hold_bad, 0);
        chk("R10 released after stop", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_mismatch();
        logic ack; int base;
        base = rx_cnt; scl_seen = 1'b0;
        m_start();
        m_write_byte({7'h2B, 1'b0}, ack); chk("R3 no address ack", ack, 0);
        m_write_byte(8'h77, ack);         chk("R3 no data ack", ack, 0);
        m_stop(); wq();
        chk("R3 nothing offered", rx_cnt - base, 0);
        chk("R3 SCL never held", scl_seen, 0);
    endtask

    task automatic t_read();
        logic ack; logic [7:0] d;
        tx_mem[0] = 8'h96; tx_mem[1] = 8'h01; tx_mem[2] = 8'hFF;
        tx_idx = 0; tx_delay = 30; hold_bad = 0;
        m_start();
        m_write_byte({OWN, 1'b1}, ack); chk("R2 address ack (read)", ack, 1);
        m_read_byte(d, 1'b1); chk("R6 read byte 1", d, 8'h96);
        m_read_byte(d, 1'b1); chk("R8 byte after ACK", d, 8'h01);
        m_read_byte(d, 1'b0); chk("R8 last byte", d, 8'hFF);
        repeat (60) @(negedge clk);
        chk("R8 no stretch after NACK", scl_oe, 0);
        chk("R8 SDA released after NACK", sda_oe, 0);
        chk("R8 no further request", tx_idx, 3);
        m_stop(); wq();
        chk("R6 held until byte supplied", hold_bad, 0);
        chk("R7 SDA moves only with SCL low", sda_bad, 0);
    endtask

    task automatic t_rstart();
        logic ack; logic [7:0] d;
        rx_delay = 5; tx_delay = 8; tx_idx = 0; tx_mem[0] = 8'hC3;
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        m_write_byte(8'h5A, ack);
        m_rstart();
        m_write_byte({OWN, 1'b1}, ack); chk("R9 address ack after Sr", ack, 1);
        m_read_byte(d, 1'b0);           chk("R9 read after Sr", d, 8'hC3);
        m_stop(); wq();
        chk("R9 write before Sr kept", rx_log[(rx_cnt - 1) % 32], 8'h5A);
    endtask

    task automatic t_mid_start();
        logic ack;
        m_start();
        m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1); m_bit_out(1'b0);
        m_rstart();
        m_write_byte({OWN, 1'b0}, ack); chk("R11 ack after START in a byte", ack, 1);
        m_write_byte(8'h81, ack);
        m_stop(); wq();
        chk("R11 framing after START in a byte", rx_log[(rx_cnt - 1) % 32], 8'h81);
    endtask

    task automatic t_mid_stop();
        logic ack; int base;
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        base = rx_cnt;
        m_bit_out(1'b1); m_bit_out(1'b1); m_bit_out(1'b0);
        m_stop(); wq();
        chk("R10 idle after STOP in a byte", {scl_oe, sda_oe}, 0);
        chk("R10 partial byte dropped", rx_cnt - base, 0);
        m_start();
        m_write_byte({OWN, 1'b0}, ack); chk("R11 ack after STOP in a byte", ack, 1);
        m_write_byte(8'h24, ack);
        m_stop(); wq();
        chk("R11 framing after STOP in a byte", rx_log[(rx_cnt - 1) % 32], 8'h24);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_write();
        t_mismatch();
        t_read();
        t_rstart();
        t_mid_start();
        t_mid_stop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule